// File: doc/BRIEF.md
# Synchronous DRAM Read Burst Sequencer

This block is the memory side of a synchronous DRAM column read path. It takes a registered command bus, a bank select and row and column addresses. A row is opened in a bank with an activate command. A read command to that bank then starts a burst, which is fetched from an internal storage array and placed on a 16-bit data output. An output-enable models the high-impedance state of the data pins: it is high only while a burst word is on `dq_out`.

A mode setting chooses the read latency (1 to 3 cycles) and the burst length (1, 2, 4, 8 or full page). A full-page burst streams until a terminate command. A second read command replaces the running burst without leaving a gap. The block times the activate-to-read delay for each bank and raises a sticky flag when a read is issued too early. The storage array holds a fixed pattern that depends only on the address, so the word order on the output is observable.

Top module: `sdram_rd_seq`

## Requirements
- R1: With `lat_sel` = L (1, 2 or 3; 0 acts as 1), the first word of a burst is on `dq_out` with `dq_oe` high right after the L-th rising edge following the edge that samples READ.
- R2: `bl_sel` encodes the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and 4, 5 and 6 give 1 word.
- R3: For a fixed burst of N words, `dq_oe` stays high for exactly N consecutive cycles and then goes low, with `dq_out` at 0.
- R4: In a fixed burst the column steps upward and wraps within the aligned block of N columns that holds the start column (N=4 from column 6 gives 6, 7, 4, 5).
- R5: In full-page mode the column steps upward, rolls from 255 to 0 and the burst continues until a terminate command.
- R6: A terminate command (`cmd` = 3) sampled at edge T with latency L leaves the last word on the output after edge T+L-1, and `dq_oe` is low after edge T+L.
- R7: A READ sampled during a running burst ends that burst. The new burst's first word follows the latency of R1, directly after the last word of the old burst, with no idle cycle.
- R8: Each output word equals bank*32768 + row*256 + column of the address it was read from.
- R9: A READ sampled at least TRCD edges after the ACT (`cmd` = 1) to its bank leaves `trcd_viol` low. A READ (`cmd` = 2) sampled earlier, or to a bank not activated since reset, sets `trcd_viol`, which then stays high until reset.
- R10: During and right after reset, `dq_oe`, `dq_out` and `trcd_viol` are all 0.
- R11: ACT latches `row_addr` for its bank. A READ reads from the row last activated in the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 0 no-op, 1 activate, 2 read, 3 burst terminate |
| bank | input | 1 | Bank select for activate and read |
| row_addr | input | ROW_W | Row address, taken with activate |
| col_addr | input | 8 | Start column, taken with read |
| lat_sel | input | 2 | Read latency in cycles (1 to 3) |
| bl_sel | input | 3 | Burst length code (see R2) |
| dq_out | output | 16 | Read data; 0 when not driven |
| dq_oe | output | 1 | High while a burst word is on dq_out; low models high impedance |
| trcd_viol | output | 1 | Sticky activate-to-read timing violation flag |

## Verification
For a READ sampled at edge E, burst word j is due right after edge E+j+L. A terminate at edge T drops `dq_oe` after edge T+L. A replacing READ at edge E+R puts its word j right after edge E+R+j+L. The violation flag is due one edge after the offending READ. The bench drives every command on a falling edge. It counts k, the rising edges since the READ edge, and samples at the next falling edge. From k, L, the burst code and the start columns it computes whether `dq_oe` should be high and which address pattern must be on `dq_out`. It does this for every latency and burst code, for start columns inside and at the end of a block, and for full-page wrap, terminate and replacement.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    localparam int COL_W   = 8;
    localparam int DW      = 16;
    localparam int MAX_LAT = 3;
    localparam int BANKS   = 2;
    localparam int LEN_W   = COL_W + 1;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2,
        CMD_TERM = 2'd3
    } cmd_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } beat_t;

    function automatic logic is_full_page(logic [2:0] code);
        return code == 3'd7;
    endfunction

    function automatic logic [LEN_W-1:0] burst_len(logic [2:0] code);
        case (code)
            3'd1:    return LEN_W'(2);
            3'd2:    return LEN_W'(4);
            3'd3:    return LEN_W'(8);
            3'd7:    return LEN_W'(256);
            default: return LEN_W'(1);
        endcase
    endfunction

    function automatic logic [1:0] eff_lat(logic [1:0] sel);
        return (sel == 2'd0) ? 2'd1 : sel;
    endfunction

    function automatic logic [COL_W-1:0] next_col(logic [COL_W-1:0] col,
                                                  logic [LEN_W-1:0] len,
                                                  logic fp);
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] inc;
        mask = COL_W'(len - LEN_W'(1));
        inc  = col + COL_W'(1);
        if (fp) return inc;
        return (col & ~mask) | (inc & mask);
    endfunction

    function automatic logic [DW-1:0] pat_word(logic b, logic [6:0] r,
                                               logic [COL_W-1:0] c);
        return {b, r, c};
    endfunction

endpackage

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer
    import sdr_pkg::*;
#(
    parameter int TRCD  = 2,
    parameter int ROW_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_hit,
    input  logic [ROW_W-1:0] row_in,
    output logic             ready,
    output logic [ROW_W-1:0] row_q
);
    localparam int CW = $clog2(TRCD + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(TRCD - 1);

    logic          open_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            row_q  <= '0;
        end else if (act_hit) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
            row_q  <= row_in;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ready = open_q && (cnt_q >= CNT_MAX);

    generate
        if (TRCD > 1) begin : g_chk
            // R9: a bank is never ready on the edge right after its activate
            a_r9_act_blocks: assert property (@(posedge clk) disable iff (rst)
                act_hit |=> !ready);
        end
    endgenerate

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
    import sdr_pkg::*;
#(
    parameter int ROW_W = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cmd_e                     cmd,
    input  logic                     bank,
    input  logic [ROW_W-1:0]         row_sel,
    input  logic [COL_W-1:0]         col,
    input  logic [2:0]               bl_code,
    output logic                     emit_vld,
    output logic [ROW_W+COL_W:0]     emit_addr
);
    typedef struct packed {
        logic             active;
        logic             fp;
        logic             bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rem;
    } burst_t;

    burst_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (cmd)
                CMD_READ: begin
                    st.active <= 1'b1;
                    st.fp     <= is_full_page(bl_code);
                    st.bank   <= bank;
                    st.row    <= row_sel;
                    st.col    <= col;
                    st.len    <= burst_len(bl_code);
                    st.rem    <= burst_len(bl_code);
                end
                CMD_TERM: st.active <= 1'b0;
                default: begin
                    if (st.active) begin
                        st.col <= next_col(st.col, st.len, st.fp);
                        if (!st.fp) begin
                            st.rem <= st.rem - LEN_W'(1);
                            if (st.rem == LEN_W'(1)) st.active <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    assign emit_vld  = st.active;
    assign emit_addr = {st.bank, st.row, st.col};

    logic quiet;
    assign quiet = (cmd == CMD_NOP) || (cmd == CMD_ACT);

    // R6: terminate stops fetching at once
    a_r6_term_stops: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_TERM) |=> !st.active);

    // R3: a fixed burst stops after its last fetch
    a_r3_fixed_ends: assert property (@(posedge clk) disable iff (rst)
        (st.active && !st.fp && st.rem == LEN_W'(1) && quiet) |=> !st.active);

    // R5: full page rolls from the last column to column 0 and keeps going
    a_r5_page_wrap: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.fp && st.col == '1 && quiet) |=> (st.active && st.col == '0));

    // R4: a fixed burst stays inside its aligned block
    a_r4_block_wrap: assert property (@(posedge clk) disable iff (rst)
        (st.active && !st.fp && st.rem > LEN_W'(1) && quiet)
        |=> ((st.col & ~COL_W'(st.len - LEN_W'(1))) ==
             ($past(st.col) & ~COL_W'(st.len - LEN_W'(1)))));

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
    import sdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  beat_t      beat_in,
    input  logic [1:0] lat,
    output beat_t      beat_out
);
    beat_t dly [1:MAX_LAT-1];
    beat_t sel;

    generate
        for (genvar i = 1; i < MAX_LAT; i++) begin : g_stage
            if (i == 1) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) dly[i] <= '0;
                    else     dly[i] <= beat_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) dly[i] <= '0;
                    else     dly[i] <= dly[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        sel = beat_in;
        for (int i = 1; i < MAX_LAT; i++) begin
            if (int'(lat) == i + 1) sel = dly[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          beat_out <= '0;
        else if (sel.vld) beat_out <= sel;
        else              beat_out <= '0;
    end

    // R1: at latency 1 a fetched word is driven on the next edge
    a_r1_lat1_next: assert property (@(posedge clk) disable iff (rst)
        (lat == 2'd1 && beat_in.vld) |=> beat_out.vld);

    // R3: an undriven output carries zero data
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !beat_out.vld |-> (beat_out.data == '0));

endmodule

// File: rtl/sdr_store.sv
module sdr_store
    import sdr_pkg::*;
#(
    parameter int ROW_W = 1
) (
    input  logic [ROW_W+COL_W:0] addr,
    output logic [DW-1:0]        rdata
);
    localparam int AW    = 1 + ROW_W + COL_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            localparam logic [AW-1:0] A = AW'(g);
            assign mem[g] = pat_word(A[AW-1], 7'(A[AW-2:COL_W]), A[COL_W-1:0]);
        end
    endgenerate

    assign rdata = mem[addr];

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdr_pkg::*;
#(
    parameter int TRCD  = 2,
    parameter int ROW_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd,
    input  logic             bank,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [7:0]       col_addr,
    input  logic [1:0]       lat_sel,
    input  logic [2:0]       bl_sel,
    output logic [15:0]      dq_out,
    output logic             dq_oe,
    output logic             trcd_viol
);
    cmd_e                 c;
    logic [BANKS-1:0]     bank_rdy;
    logic [ROW_W-1:0]     bank_row [BANKS];
    logic                 emit_vld;
    logic [ROW_W+COL_W:0] emit_addr;
    logic [DW-1:0]        rdata;
    beat_t                beat_in;
    beat_t                beat_out;

    assign c = cmd_e'(cmd);

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            sdr_bank_timer #(.TRCD(TRCD), .ROW_W(ROW_W)) u_timer (
                .clk     (clk),
                .rst     (rst),
                .act_hit (c == CMD_ACT && int'(bank) == b),
                .row_in  (row_addr),
                .ready   (bank_rdy[b]),
                .row_q   (bank_row[b])
            );
        end
    endgenerate

    sdr_burst_gen #(.ROW_W(ROW_W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .cmd       (c),
        .bank      (bank),
        .row_sel   (bank_row[bank]),
        .col       (col_addr),
        .bl_code   (bl_sel),
        .emit_vld  (emit_vld),
        .emit_addr (emit_addr)
    );

    sdr_store #(.ROW_W(ROW_W)) u_store (
        .addr  (emit_addr),
        .rdata (rdata)
    );

    assign beat_in.vld  = emit_vld;
    assign beat_in.data = emit_vld ? rdata : '0;

    sdr_lat_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .beat_in  (beat_in),
        .lat      (eff_lat(lat_sel)),
        .beat_out (beat_out)
    );

    always_ff @(posedge clk) begin
        if (rst)                                trcd_viol <= 1'b0;
        else if (c == CMD_READ && !bank_rdy[bank]) trcd_viol <= 1'b1;
    end

    assign dq_out = beat_out.data;
    assign dq_oe  = beat_out.vld;

    // R9: the violation flag never clears without reset
    a_r9_viol_sticky: assert property (@(posedge clk) disable iff (rst)
        trcd_viol |=> trcd_viol);

    // R8: a driven word always comes from the fetch path
    a_r8_oe_from_fetch: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(emit_vld) || $past(u_pipe.dly[1].vld) || $past(u_pipe.dly[2].vld));

endmodule

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'd0;
    logic        bank = 1'b0;
    logic [0:0]  row_addr = 1'b0;
    logic [7:0]  col_addr = 8'd0;
    logic [1:0]  lat_sel = 2'd1;
    logic [2:0]  bl_sel = 3'd0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        trcd_viol;

    int n_cmp = 0;
    int n_bad = 0;
    int bank_row [2];

    always #4 clk = ~clk;

    sdram_rd_seq u_sdram_rd_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .bank      (bank),
        .row_addr  (row_addr),
        .col_addr  (col_addr),
        .lat_sel   (lat_sel),
        .bl_sel    (bl_sel),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .trcd_viol (trcd_viol)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int blen_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int ecol(input int st, input int code, input int j);
        int m;
        if (code == 7) return (st + j) % 256;
        m = blen_of(code) - 1;
        return (st & ~m) | ((st + j) & m);
    endfunction

    function automatic int exp_word(input int b, input int r, input int c);
        return b * 32768 + r * 256 + c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_act(input int b, input int r);
        @(negedge clk);
        cmd = 2'd1;
        bank = b[0];
        row_addr = r[0:0];
        bank_row[b] = r;
        @(negedge clk);
        cmd = 2'd0;
    endtask

    // term_k / rd2_k: edge offset from the READ edge, -1 for none
    task automatic run_burst(input int l, input int code, input int b, input int st,
                             input int term_k, input int rd2_k, input int st2,
                             input string req);
        int blen, horizon;
        blen = blen_of(code);
        if (term_k >= 0)      horizon = term_k + l + 3;
        else if (rd2_k >= 0)  horizon = rd2_k + blen + l + 3;
        else                  horizon = blen + l + 3;
        @(negedge clk);
        lat_sel = l[1:0];
        bl_sel = code[2:0];
        cmd = 2'd2;
        bank = b[0];
        col_addr = st[7:0];
        @(negedge clk);
        cmd = 2'd0;
        for (int k = 0; k <= horizon; k++) begin
            int idx, lim, c;
            bit on;
            idx = k - l;
            on = 1'b0;
            c = 0;
            if (idx >= 0) begin
                if (rd2_k >= 0 && idx >= rd2_k) begin
                    on = (idx - rd2_k) < blen;
                    c = ecol(st2, code, idx - rd2_k);
                end else begin
                    lim = (code == 7) ? term_k : blen;
                    if (term_k >= 0 && term_k < lim) lim = term_k;
                    on = idx < lim;
                    c = ecol(st, code, idx);
                end
            end
            chk(dq_oe == on, {req, " oe"}, int'(dq_oe), int'(on));
            if (on)
                chk(dq_out == 16'(exp_word(b, bank_row[b], c)), {req, " data"},
                    int'(dq_out), exp_word(b, bank_row[b], c));
            else
                chk(dq_out == 16'd0, {req, " idle zero"}, int'(dq_out), 0);
            if (k == term_k - 1) begin
                cmd = 2'd3;
            end else if (k == rd2_k - 1) begin
                cmd = 2'd2;
                col_addr = st2[7:0];
            end else begin
                cmd = 2'd0;
            end
            @(negedge clk);
        end
        cmd = 2'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(dq_oe == 1'b0, "R10 oe", int'(dq_oe), 0);
        chk(dq_out == 16'd0, "R10 dq", int'(dq_out), 0);
        chk(trcd_viol == 1'b0, "R10 viol", int'(trcd_viol), 0);

        // R9, R11: open both banks with different rows; READ exactly TRCD later
        do_act(1, 0);
        do_act(0, 1);

        // R1 R2 R3 R4 R8: every latency, fixed lengths, in-block and end-of-block starts
        for (int l = 1; l <= 3; l++)
            for (int code = 0; code <= 3; code++) begin
                run_burst(l, code, 0, 6, -1, -1, 0, "R1/R2/R3/R4/R8");
                run_burst(l, code, 1, 253, -1, -1, 0, "R1/R2/R3/R4/R8");
            end

        // R2: reserved codes give a single word
        run_burst(2, 5, 0, 9, -1, -1, 0, "R2 reserved");
        run_burst(1, 4, 1, 17, -1, -1, 0, "R2 reserved");

        // R5 R6: full page crosses column 255 and is ended by terminate
        for (int l = 1; l <= 3; l++)
            run_burst(l, 7, l % 2, 250, 12, -1, 0, "R5/R6");

        // R6: terminate cuts a fixed burst
        run_burst(2, 3, 0, 0, 3, -1, 0, "R6 fixed");

        // R7: a second READ replaces the burst with no gap
        for (int l = 1; l <= 3; l++)
            run_burst(l, 3, 1, 2, -1, 3, 8'h41, "R7");

        chk(trcd_viol == 1'b0, "R9 legal reads", int'(trcd_viol), 0);

        // R11: reopen bank 0 on another row
        do_act(0, 0);
        run_burst(2, 2, 0, 33, -1, -1, 0, "R11");
        chk(trcd_viol == 1'b0, "R9 legal after reopen", int'(trcd_viol), 0);

        // R9: READ one edge after activate is early
        do_act(1, 1);
        cmd = 2'd2;
        bank = 1'b1;
        bl_sel = 3'd0;
        @(negedge clk);
        cmd = 2'd0;
        chk(trcd_viol == 1'b1, "R9 early read", int'(trcd_viol), 1);
        repeat (10) @(negedge clk);
        chk(trcd_viol == 1'b1, "R9 sticky", int'(trcd_viol), 1);

        // R9: READ to a bank not opened since reset
        do_reset();
        chk(trcd_viol == 1'b0, "R10 viol cleared", int'(trcd_viol), 0);
        cmd = 2'd2;
        bank = 1'b0;
        @(negedge clk);
        cmd = 2'd0;
        chk(trcd_viol == 1'b1, "R9 unopened bank", int'(trcd_viol), 1);
        repeat (6) @(negedge clk);

        summary();
        $finish;
    end

endmodule